// File: doc/BRIEF.md
# Asynchronous Byte-Wide ROM Read Sequencer

This block lets a synchronous host read single bytes from an external asynchronous one-time-programmable memory of 64K by 8 bits. The host holds a request with an address until it sees a one-cycle acknowledge with the byte. For each request the block drives the address and the active-low chip select. It lowers the active-low output-drive enable only as late as the access allows, and it registers the data bus on the first clock edge at which every access delay has elapsed.

All timing is given in picoseconds as parameters together with the clock period. Each delay becomes a cycle count of ceil(delay / period) + 1, where the extra cycle covers synchronization. The delays are address-to-data, select-to-data, enable-to-data, bus float and output hold. A standby option returns the chip select high after every access. With standby off, the select stays low once it has been asserted, so later reads wait only for the address and enable delays. After every access, the bus release time must pass before the next access may start.

Top module: `rom_read_ctrl`

## Requirements
- R1: A synchronous active-low reset takes the block to idle within one clock edge, with `mem_ce_n_o` = 1, `mem_oe_n_o` = 1 and `rd_ack_o` = 0.
- R2: Every delay parameter maps to N = ceil(delay_ps / CLK_PERIOD_PS) + 1 cycles. With the defaults (4000 ps clock; 45000, 45000, 20000, 20000 and 7000 ps) this gives address 13, select 13, enable 6, float 6 and hold 3.
- R3: The enable goes low on the first edge at which the address age has reached N_acc − N_oe and the select age has reached N_ce − N_oe, each taken as at least 1. That edge is therefore exactly N_oe edges before the capture edge.
- R4: The data byte is registered, and `rd_ack_o` pulses high for exactly one cycle, on the first edge at which the address age is at least N_acc, the select age at least N_ce and the enable age at least N_oe. `rd_data_o` then holds the byte that the memory presented for that address.
- R5: `mem_oe_n_o` is low only while `mem_ce_n_o` is low, and `mem_addr_o` does not change while `mem_oe_n_o` is low.
- R6: On the capture edge `mem_oe_n_o` returns high. With STANDBY = 1, `mem_ce_n_o` also returns high on that edge.
- R7: With STANDBY = 0, `mem_ce_n_o` stays low after the first access. Later reads then complete N_acc edges after they start, even when N_ce is larger.
- R8: An access starts no earlier than max(N_df, N_oh) edges after the capture edge of the previous access. An access starts when the address is loaded, and the select falls with it if it was high. A request that is already waiting starts exactly at that edge.
- R9: A request that is high before a clock edge while the block is idle starts an access on that edge. A request kept high after the acknowledge, with a new address, is served as a back-to-back read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req_i | input | 1 | Host read request, held until acknowledged |
| rd_addr_i | input | ADDR_W | Host byte address |
| rd_ack_o | output | 1 | One-cycle pulse when rd_data_o is valid |
| rd_data_o | output | DATA_W | Byte captured by the last access |
| mem_addr_o | output | ADDR_W | Address lines to the memory |
| mem_ce_n_o | output | 1 | Memory chip select, active low |
| mem_oe_n_o | output | 1 | Memory output-drive enable, active low |
| mem_data_i | input | DATA_W | Data lines from the memory |

## Verification
The bench numbers the rising edges and computes the edge on which each access starts. That edge is the later of the request edge and the previous capture edge plus max(N_df, N_oh). The acknowledge is then due max(N_acc, N_ce) edges after the start, or N_acc edges after it on a non-first read without standby. The enable fall is due exactly N_oe edges before the acknowledge, and with standby the select fall is due on the start edge itself. A memory model in the bench returns the inverted byte until every age condition is met, so capturing one edge early shows up as a data mismatch. All outputs are sampled on the falling clock edge, half a cycle after the edge that changed them, and are compared against these predicted edge numbers.

// File: rtl/rom_rd_pkg.sv
// Shared types and helpers for the asynchronous ROM read sequencer.
// Assumes all delays and the clock period are positive integers in picoseconds.
package rom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_RECOVER = 2'd2
    } rd_state_e;

    localparam int NUM_TMR  = 4;
    localparam int TMR_ADDR = 0;
    localparam int TMR_CE   = 1;
    localparam int TMR_OE   = 2;
    localparam int TMR_REC  = 3;

    // Converts a delay into whole clock cycles plus one synchronization cycle.
    function automatic int delay_to_cycles(input int delay_ps, input int period_ps);
        return (delay_ps + period_ps - 1) / period_ps + 1;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rom_rd_age.sv
// Saturating age counter: counts clock edges since the last start pulse.
// After a start on edge k the value read before edge k+n is n. A value of
// zero means the counter was never started since reset.
module rom_rd_age #(
    parameter int CNT_W   = 5,
    parameter int SAT_VAL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic [CNT_W-1:0] age_o
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_VAL);

    // Restarts at one on a start pulse, otherwise climbs until saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_o <= '0;
        end else if (start_i) begin
            age_o <= CNT_W'(1);
        end else if ((age_o != '0) && (age_o < SAT)) begin
            age_o <= age_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rom_rd_gate.sv
// Timing gate: compares the four ages against the cycle budgets and reports
// when the enable may fall, when data may be captured and when the bus has
// recovered. Purely combinational; assumes ages saturate at or above every
// budget.
module rom_rd_gate #(
    parameter int CNT_W   = 5,
    parameter int ACC_CYC = 13,
    parameter int CE_CYC  = 13,
    parameter int OE_CYC  = 6,
    parameter int REC_CYC = 6
) (
    input  logic [CNT_W-1:0] age_addr_i,
    input  logic [CNT_W-1:0] age_ce_i,
    input  logic [CNT_W-1:0] age_oe_i,
    input  logic [CNT_W-1:0] age_rec_i,
    output logic             oe_go_o,
    output logic             cap_go_o,
    output logic             rec_done_o
);

    import rom_rd_pkg::*;

    localparam int LEAD_A = imax(ACC_CYC - OE_CYC, 1);
    localparam int LEAD_C = imax(CE_CYC - OE_CYC, 1);

    // Late enable point, capture point and float recovery point.
    always_comb begin
        oe_go_o    = (age_addr_i >= CNT_W'(LEAD_A)) && (age_ce_i >= CNT_W'(LEAD_C));
        cap_go_o   = (age_addr_i >= CNT_W'(ACC_CYC)) && (age_ce_i >= CNT_W'(CE_CYC))
                     && (age_oe_i >= CNT_W'(OE_CYC));
        rec_done_o = (age_rec_i >= CNT_W'(REC_CYC));
    end

endmodule

// File: rtl/rom_rd_seq.sv
// Access sequencer: accepts host requests, drives the memory address, select
// and enable, captures the data byte and emits the acknowledge. Timing
// decisions come from the gate; this module only orders the steps. Assumes
// the host keeps rd_req and its address steady until the acknowledge.
module rom_rd_seq #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter bit STANDBY = 1'b1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [DATA_W-1:0]               mem_data_i,
    input  logic                            oe_go_i,
    input  logic                            cap_go_i,
    input  logic                            rec_done_i,
    output logic [ADDR_W-1:0]               mem_addr_o,
    output logic                            mem_ce_n_o,
    output logic                            mem_oe_n_o,
    output logic                            ack_o,
    output logic [DATA_W-1:0]               rdata_o,
    output logic [rom_rd_pkg::NUM_TMR-1:0]  tmr_start_o
);

    import rom_rd_pkg::*;

    rd_state_e state_q;
    logic      begin_acc;
    logic      drop_oe;
    logic      capture;
    logic      ce_release;

    // The standby variant releases the select together with the enable.
    generate
        if (STANDBY) begin : g_standby
            assign ce_release = 1'b1;
        end else begin : g_keep_ce
            assign ce_release = 1'b0;
        end
    endgenerate

    // Decodes the step taken on the coming edge and the timers it restarts.
    always_comb begin
        begin_acc = req_i && ((state_q == ST_IDLE) ||
                              ((state_q == ST_RECOVER) && rec_done_i));
        drop_oe   = (state_q == ST_ACCESS) && mem_oe_n_o && oe_go_i;
        capture   = (state_q == ST_ACCESS) && !mem_oe_n_o && cap_go_i;
        tmr_start_o           = '0;
        tmr_start_o[TMR_ADDR] = begin_acc;
        tmr_start_o[TMR_CE]   = begin_acc && mem_ce_n_o;
        tmr_start_o[TMR_OE]   = drop_oe;
        tmr_start_o[TMR_REC]  = capture;
    end

    // State register: idle, access in flight, bus recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (begin_acc) state_q <= ST_ACCESS;
                ST_ACCESS:  if (capture)   state_q <= ST_RECOVER;
                ST_RECOVER: begin
                    if (begin_acc)       state_q <= ST_ACCESS;
                    else if (rec_done_i) state_q <= ST_IDLE;
                end
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory-side pins, captured byte and acknowledge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr_o <= '0;
            mem_ce_n_o <= 1'b1;
            mem_oe_n_o <= 1'b1;
            ack_o      <= 1'b0;
            rdata_o    <= '0;
        end else begin
            ack_o <= 1'b0;
            if (begin_acc) begin
                mem_addr_o <= addr_i;
                mem_ce_n_o <= 1'b0;
            end
            if (drop_oe) begin
                mem_oe_n_o <= 1'b0;
            end
            if (capture) begin
                rdata_o    <= mem_data_i;
                ack_o      <= 1'b1;
                mem_oe_n_o <= 1'b1;
                if (ce_release) begin
                    mem_ce_n_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rom_read_ctrl.sv
// Top level of the asynchronous ROM read sequencer. Converts the picosecond
// timing set into cycle budgets, builds one age counter per timed event and
// joins them to the gate and the sequencer. Assumes the memory data lines
// meet setup to clk once the budgets have elapsed (one budget cycle is spare
// for that purpose).
module rom_read_ctrl #(
    parameter int ADDR_W        = 16,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_PS = 4000,
    parameter int T_ACC_PS      = 45000,
    parameter int T_CE_PS       = 45000,
    parameter int T_OE_PS       = 20000,
    parameter int T_DF_PS       = 20000,
    parameter int T_OH_PS       = 7000,
    parameter bit STANDBY       = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              rd_ack_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    input  logic [DATA_W-1:0] mem_data_i
);

    import rom_rd_pkg::*;

    localparam int ACC_CYC = delay_to_cycles(T_ACC_PS, CLK_PERIOD_PS);
    localparam int CE_CYC  = delay_to_cycles(T_CE_PS, CLK_PERIOD_PS);
    localparam int OE_CYC  = delay_to_cycles(T_OE_PS, CLK_PERIOD_PS);
    localparam int DF_CYC  = delay_to_cycles(T_DF_PS, CLK_PERIOD_PS);
    localparam int OH_CYC  = delay_to_cycles(T_OH_PS, CLK_PERIOD_PS);
    localparam int REC_CYC = imax(DF_CYC, OH_CYC);
    localparam int SAT_CYC = imax(imax(ACC_CYC, CE_CYC), imax(OE_CYC, REC_CYC));
    localparam int CNT_W   = $clog2(SAT_CYC + 1);

    logic [NUM_TMR-1:0] tmr_start;
    logic [CNT_W-1:0]   age [NUM_TMR];
    logic               oe_go;
    logic               cap_go;
    logic               rec_done;

    // One age counter per timed event: address, select, enable, recovery.
    generate
        for (genvar t = 0; t < NUM_TMR; t++) begin : g_age
            rom_rd_age #(
                .CNT_W   (CNT_W),
                .SAT_VAL (SAT_CYC)
            ) u_age (
                .clk     (clk),
                .rst_n   (rst_n),
                .start_i (tmr_start[t]),
                .age_o   (age[t])
            );
        end
    endgenerate

    rom_rd_gate #(
        .CNT_W   (CNT_W),
        .ACC_CYC (ACC_CYC),
        .CE_CYC  (CE_CYC),
        .OE_CYC  (OE_CYC),
        .REC_CYC (REC_CYC)
    ) u_gate (
        .age_addr_i (age[TMR_ADDR]),
        .age_ce_i   (age[TMR_CE]),
        .age_oe_i   (age[TMR_OE]),
        .age_rec_i  (age[TMR_REC]),
        .oe_go_o    (oe_go),
        .cap_go_o   (cap_go),
        .rec_done_o (rec_done)
    );

    rom_rd_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .STANDBY (STANDBY)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (rd_req_i),
        .addr_i      (rd_addr_i),
        .mem_data_i  (mem_data_i),
        .oe_go_i     (oe_go),
        .cap_go_i    (cap_go),
        .rec_done_i  (rec_done),
        .mem_addr_o  (mem_addr_o),
        .mem_ce_n_o  (mem_ce_n_o),
        .mem_oe_n_o  (mem_oe_n_o),
        .ack_o       (rd_ack_o),
        .rdata_o     (rd_data_o),
        .tmr_start_o (tmr_start)
    );

endmodule

// File: rtl/rom_rd_chk.sv
// Protocol checker for the ROM read sequencer, bound to every instance of
// the top. Watches only the memory pins and the acknowledge. The recovery
// gaps are measured with local counters rather than long $past windows.
module rom_rd_chk #(
    parameter int ADDR_W        = 16,
    parameter int CLK_PERIOD_PS = 4000,
    parameter int T_DF_PS       = 20000,
    parameter int T_OH_PS       = 7000,
    parameter bit STANDBY       = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_ack_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_ce_n_o,
    input logic              mem_oe_n_o
);

    import rom_rd_pkg::*;

    localparam int REC_CYC = imax(delay_to_cycles(T_DF_PS, CLK_PERIOD_PS),
                                  delay_to_cycles(T_OH_PS, CLK_PERIOD_PS));
    localparam int GAP_SAT = REC_CYC + 2;

    int   oe_gap;
    int   ce_gap;
    logic oe_prev;
    logic ce_prev;

    // Counts edges since each pin last rose; starts saturated after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_gap  <= GAP_SAT;
            ce_gap  <= GAP_SAT;
            oe_prev <= 1'b1;
            ce_prev <= 1'b1;
        end else begin
            oe_prev <= mem_oe_n_o;
            ce_prev <= mem_ce_n_o;
            if (mem_oe_n_o && !oe_prev)  oe_gap <= 1;
            else if (oe_gap < GAP_SAT)   oe_gap <= oe_gap + 1;
            if (mem_ce_n_o && !ce_prev)  ce_gap <= 1;
            else if (ce_gap < GAP_SAT)   ce_gap <= ce_gap + 1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (mem_ce_n_o && mem_oe_n_o && !rd_ack_o));

    p_oe_under_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> !mem_ce_n_o);

    p_addr_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n_o |-> $stable(mem_addr_o));

    p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_o |=> !rd_ack_o);

    p_ack_drops_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_o |-> mem_oe_n_o);

    p_ack_ce_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_o |-> (mem_ce_n_o == STANDBY));

    p_oe_float_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n_o) |-> (oe_gap >= REC_CYC));

    p_ce_float_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n_o) |-> (ce_gap >= REC_CYC));

endmodule

bind rom_read_ctrl rom_rd_chk #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .T_DF_PS       (T_DF_PS),
    .T_OH_PS       (T_OH_PS),
    .STANDBY       (STANDBY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_ack_o   (rd_ack_o),
    .mem_addr_o (mem_addr_o),
    .mem_ce_n_o (mem_ce_n_o),
    .mem_oe_n_o (mem_oe_n_o)
);

// File: tb/rom_read_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: instance 0 uses the defaults (standby on); instance 1 has standby off
// and a slower select delay. A cycle-level memory model returns the inverted
// byte until every access age is met.
module rom_read_ctrl_tb;

    localparam int PER_PS = 4000;
    localparam int T_ACC  = 45000;
    localparam int T_OE   = 20000;
    localparam int T_DF   = 20000;
    localparam int T_OH   = 7000;
    localparam int T_CE0  = 45000;
    localparam int T_CE1  = 60000;

    function automatic int cyc(input int ps);
        return (ps + PER_PS - 1) / PER_PS + 1;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    function automatic logic [7:0] rom_fn(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    localparam int ACC_C = cyc(T_ACC);
    localparam int OE_C  = cyc(T_OE);
    localparam int REC_C = mx(cyc(T_DF), cyc(T_OH));

    int ce_c [2];
    bit stby [2];

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_s   [2];
    logic [15:0] addr_s  [2];
    logic        ack_s   [2];
    logic [7:0]  rdata_s [2];
    logic [15:0] maddr_s [2];
    logic        ce_s    [2];
    logic        oe_s    [2];
    logic [7:0]  mdata_s [2];

    int ecnt = 0;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    int a_age [2];
    int c_age [2];
    int o_age [2];
    logic [15:0] last_a [2];
    int  oe_fall_e [2];
    int  ce_fall_e [2];
    int  last_ack  [2];
    bit  have_prev [2];
    bit  first     [2];
    logic prev_oe [2];
    logic prev_ce [2];
    logic prev_ack [2];

    always #2 clk = ~clk;

    rom_read_ctrl u_dut (
        .clk (clk), .rst_n (rst_n),
        .rd_req_i (req_s[0]), .rd_addr_i (addr_s[0]),
        .rd_ack_o (ack_s[0]), .rd_data_o (rdata_s[0]),
        .mem_addr_o (maddr_s[0]), .mem_ce_n_o (ce_s[0]),
        .mem_oe_n_o (oe_s[0]), .mem_data_i (mdata_s[0])
    );

    rom_read_ctrl #(.T_CE_PS (T_CE1), .STANDBY (1'b0)) u_dut_nsb (
        .clk (clk), .rst_n (rst_n),
        .rd_req_i (req_s[1]), .rd_addr_i (addr_s[1]),
        .rd_ack_o (ack_s[1]), .rd_data_o (rdata_s[1]),
        .mem_addr_o (maddr_s[1]), .mem_ce_n_o (ce_s[1]),
        .mem_oe_n_o (oe_s[1]), .mem_data_i (mdata_s[1])
    );

    // Edge counter: value seen at a falling edge is the index of the last rising edge.
    always @(posedge clk) ecnt <= ecnt + 1;

    // Memory model ages, counted in rising edges since each condition began.
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (maddr_s[k] !== last_a[k]) a_age[k] <= 1;
            else if (a_age[k] < 1000)     a_age[k] <= a_age[k] + 1;
            last_a[k] <= maddr_s[k];
            if (ce_s[k] !== 1'b0)         c_age[k] <= 0;
            else if (c_age[k] < 1000)     c_age[k] <= c_age[k] + 1;
            if (oe_s[k] !== 1'b0)         o_age[k] <= 0;
            else if (o_age[k] < 1000)     o_age[k] <= o_age[k] + 1;
        end
    end

    always @* begin
        for (int k = 0; k < 2; k++) begin
            if (!ce_s[k] && !oe_s[k] && a_age[k] >= ACC_C - 1 &&
                c_age[k] >= ce_c[k] - 1 && o_age[k] >= OE_C - 1)
                mdata_s[k] = rom_fn(maddr_s[k]);
            else
                mdata_s[k] = ~rom_fn(maddr_s[k]);
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Pin monitor on the falling edge: records fall edges and checks ack width.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                if (prev_oe[k] && !oe_s[k]) oe_fall_e[k] = ecnt;
                if (prev_ce[k] && !ce_s[k]) ce_fall_e[k] = ecnt;
                if (prev_ack[k] && ack_s[k])
                    chk(1'b0, "R4 ack wider than one cycle", 1, 0);
            end
        end
        for (int k = 0; k < 2; k++) begin
            prev_oe[k]  = oe_s[k];
            prev_ce[k]  = ce_s[k];
            prev_ack[k] = ack_s[k];
        end
    end

    // Raises a request at a falling edge and checks the whole access.
    task automatic issue(input int k, input logic [15:0] a);
        int req_e, start_e, lat, waited;
        req_s[k]  = 1'b1;
        addr_s[k] = a;
        req_e     = ecnt + 1;
        start_e   = (have_prev[k] && (last_ack[k] + REC_C > req_e)) ?
                    last_ack[k] + REC_C : req_e;
        lat = (stby[k] || first[k]) ? mx(ACC_C, ce_c[k]) : ACC_C;
        lat = mx(lat, OE_C);
        waited = 0;
        @(negedge clk);
        while (!ack_s[k] && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        if (!ack_s[k]) begin
            chk(1'b0, "R4 acknowledge missing", 0, 1);
        end else begin
            chk(ecnt == start_e + lat, "R2 R4 R9 ack edge", ecnt, start_e + lat);
            if (!stby[k] && !first[k])
                chk(ecnt == start_e + ACC_C, "R7 select kept low, address-only latency",
                    ecnt - start_e, ACC_C);
            chk(rdata_s[k] == rom_fn(a), "R4 captured byte", rdata_s[k], rom_fn(a));
            chk(oe_fall_e[k] == ecnt - OE_C, "R3 late enable edge", oe_fall_e[k], ecnt - OE_C);
            chk(oe_s[k] == 1'b1, "R6 enable released at capture", oe_s[k], 1);
            chk(ce_s[k] == stby[k], "R6 R7 select level after capture", ce_s[k], stby[k]);
            chk(maddr_s[k] == a, "R5 address on pins", maddr_s[k], a);
            if (stby[k])
                chk(ce_fall_e[k] == start_e, "R8 R9 access start edge", ce_fall_e[k], start_e);
            last_ack[k]  = ecnt;
            have_prev[k] = 1'b1;
            first[k]     = 1'b0;
        end
    endtask

    task automatic idle(input int k, input int n);
        req_s[k] = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_flags();
        for (int k = 0; k < 2; k++) begin
            have_prev[k] = 1'b0;
            first[k]     = 1'b1;
        end
    endtask

    task automatic rand_run(input int k, input int n);
        for (int i = 0; i < n; i++) begin
            issue(k, 16'($urandom));
            if ($urandom % 2 == 0) idle(k, 1 + int'($urandom % 8));
        end
        idle(k, 1);
    endtask

    initial begin
        ce_c[0] = cyc(T_CE0); ce_c[1] = cyc(T_CE1);
        stby[0] = 1'b1;       stby[1] = 1'b0;
        for (int k = 0; k < 2; k++) begin
            req_s[k] = 1'b0; addr_s[k] = '0;
            a_age[k] = 0; c_age[k] = 0; o_age[k] = 0; last_a[k] = '0;
            oe_fall_e[k] = -1; ce_fall_e[k] = -1; last_ack[k] = 0;
            prev_oe[k] = 1'b1; prev_ce[k] = 1'b1; prev_ack[k] = 1'b0;
        end
        reset_flags();
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(ce_s[k] && oe_s[k] && !ack_s[k], "R1 reset idle pins",
                {ce_s[k], oe_s[k], ack_s[k]}, 3'b110);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: address extremes, then a back-to-back pair (R8 exact start).
        issue(0, 16'h0000);
        idle(0, 4);
        issue(0, 16'hFFFF);
        issue(0, 16'h1234);
        issue(0, 16'h1234);
        idle(0, 2);
        rand_run(0, 50);

        // Standby off: first read pays the select delay, later ones do not (R7).
        issue(1, 16'h8001);
        issue(1, 16'h7FFE);
        idle(1, 3);
        issue(1, 16'h00FF);
        rand_run(1, 25);

        // Reset in the middle of an access returns the pins to idle (R1).
        req_s[0] = 1'b1; addr_s[0] = 16'hBEEF;
        repeat (8) @(negedge clk);
        rst_n = 1'b0;
        req_s[0] = 1'b0;
        @(negedge clk);
        chk(ce_s[0] && oe_s[0] && !ack_s[0], "R1 reset during access",
            {ce_s[0], oe_s[0], ack_s[0]}, 3'b110);
        chk(ce_s[1] == 1'b1, "R1 reset releases kept select", ce_s[1], 1);
        rst_n = 1'b1;
        reset_flags();
        @(negedge clk);
        issue(0, 16'hBEEF);
        idle(0, 1);
        issue(1, 16'hC0DE);
        issue(1, 16'hC0DF);
        idle(1, 2);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule